// File: doc/BRIEF.md
# Reciprocal Square Root Operand Conditioner

This block prepares one IEEE single-precision operand before an iterative reciprocal square root unit works on it. It sorts the input into a class: NaN, negative, zero, positive infinity, or a positive finite value. Each special class takes its own bypass. That bypass produces a finished operand and a finished seed, keeps the iteration idle, and may raise an invalid exception.

A positive finite value goes through the normal path. If its effective biased exponent is small, the value is multiplied by 2^64 so that later steps keep full precision, and an adjust code tells the downstream exponent fix-up to undo the scaling. The multiply works on the exponent only. A subnormal input is normalized first, so its exponent field is rebuilt from the position of its leading one.

A one-cycle strobe presents the input. All results come out of registers one clock later. Between strobes the data outputs hold their last values, while the valid and invalid pulses stay low.

Top module: `rsqrt_prescale`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When no strobe arrives, `op_out`, `seed_out`, `adj_out` and `run_out` keep their previous values, and `invalid_out` is low.
- R2: A NaN input (exponent field 0xFF, nonzero fraction, either sign) gives 0xFFFFFFFF on both `op_out` and `seed_out`, with `run_out`=0 and `adj_out`=0x00. `invalid_out` is raised only when fraction bit 22 (the quiet bit) is 0.
- R3: A negative input that is not zero and not NaN gives 0xFFFFFFFF on both outputs, raises `invalid_out`, and gives `run_out`=0 and `adj_out`=0x00. Negative infinity and negative subnormals are included.
- R4: A zero input of either sign is copied bit for bit to `op_out`. `seed_out` becomes 0x3F800000 (1.0), `run_out`=0, and there is no invalid.
- R5: Positive infinity (0x7F800000) gives 0x7F800000 on both outputs, with `run_out`=0 and no invalid.
- R6: A positive normal input with exponent field 25 or more is copied unchanged to `op_out`, with `adj_out`=0x00, `seed_out`=0 and `run_out`=1.
- R7: A positive normal input with exponent field from 1 to 24 leaves `op_out` with exponent field +64 and the fraction unchanged, with `adj_out`=0xE0, `seed_out`=0 and `run_out`=1.
- R8: A positive subnormal input with its leading one at fraction bit p is normalized and then scaled. The exponent field becomes p+42, and the fraction is the input fraction shifted left by 23-p, with the leading one removed. `adj_out`=0xE0, `seed_out`=0 and `run_out`=1.
- R9: `run_out` and `invalid_out` are never high together, and `invalid_out` is never high without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| op_out | output | 32 | Conditioned operand |
| seed_out | output | 32 | Seed or final special-case result |
| adj_out | output | 8 | Exponent adjust code (0x00 or 0xE0) |
| run_out | output | 1 | Iteration must run on `op_out` |
| invalid_out | output | 1 | Invalid-operation exception pulse |

## Verification
The assertions check on every cycle the relations that follow from the output values alone. These are: the strobe latency, holding outputs between strobes, the default NaN on any invalid, run never sharing a cycle with invalid, a zero seed whenever run is set, and the exponent window that any scaled result must fall in. Only the bench scenarios can show that each input class reaches the right bypass. The same goes for the exact split at exponent 24 and 25, the quiet-bit rule for NaN invalid, negative zero taking the zero path, and the exact normalized fraction and exponent for subnormals with their leading one at different positions.

// File: rtl/rsqrt_prescale.sv
module rsqrt_prescale (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [31:0] op_out,
  output logic [31:0] seed_out,
  output logic [7:0]  adj_out,
  output logic        run_out,
  output logic        invalid_out
);

  localparam logic [31:0] QNAN_ALL = 32'hFFFF_FFFF;
  localparam logic [31:0] ONE_F    = 32'h3F80_0000;
  localparam logic [31:0] PINF_F   = 32'h7F80_0000;
  localparam logic [7:0]  SCALE_E  = 8'd64;
  localparam logic [7:0]  SMALL_E  = 8'd24;
  localparam logic [7:0]  TAG_SCL  = 8'hE0;
  localparam logic [7:0]  SUB_BASE = 8'd42;

  logic       sgn;
  logic [7:0] ex;
  logic [22:0] fr;

  assign sgn = in_data[31];
  assign ex  = in_data[30:23];
  assign fr  = in_data[22:0];

  logic is_nan, is_inf, is_zero, is_sub;
  assign is_nan  = (ex == 8'hFF) && (fr != 23'd0);
  assign is_inf  = (ex == 8'hFF) && (fr == 23'd0);
  assign is_zero = (ex == 8'd0)  && (fr == 23'd0);
  assign is_sub  = (ex == 8'd0)  && (fr != 23'd0);

  logic [4:0] lead;
  always_comb begin
    lead = 5'd0;
    for (int i = 0; i < 23; i++)
      if (fr[i]) lead = 5'(i);
  end

  logic [22:0] sub_fr;
  logic [7:0]  sub_ex;
  assign sub_fr = 23'(fr << (5'd23 - lead));
  assign sub_ex = {3'b000, lead} + SUB_BASE;

  logic [31:0] n_op, n_seed;
  logic [7:0]  n_adj;
  logic        n_run, n_inv;

  always_comb begin
    n_op   = in_data;
    n_seed = 32'd0;
    n_adj  = 8'd0;
    n_run  = 1'b0;
    n_inv  = 1'b0;
    if (is_nan) begin
      n_op   = QNAN_ALL;
      n_seed = QNAN_ALL;
      n_inv  = ~fr[22];
    end else if (is_zero) begin
      n_seed = ONE_F;
    end else if (sgn) begin
      n_op   = QNAN_ALL;
      n_seed = QNAN_ALL;
      n_inv  = 1'b1;
    end else if (is_inf) begin
      n_op   = PINF_F;
      n_seed = PINF_F;
    end else begin
      n_run = 1'b1;
      if (is_sub) begin
        n_op  = {1'b0, sub_ex, sub_fr};
        n_adj = TAG_SCL;
      end else if (ex <= SMALL_E) begin
        n_op  = {1'b0, ex + SCALE_E, fr};
        n_adj = TAG_SCL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      op_out      <= 32'd0;
      seed_out    <= 32'd0;
      adj_out     <= 8'd0;
      run_out     <= 1'b0;
      invalid_out <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      invalid_out <= in_valid & n_inv;
      if (in_valid) begin
        op_out   <= n_op;
        seed_out <= n_seed;
        adj_out  <= n_adj;
        run_out  <= n_run;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !invalid_out && $stable(op_out) && $stable(seed_out)
                  && $stable(adj_out) && $stable(run_out));
  p_nan_on_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_out |-> (op_out == QNAN_ALL) && (seed_out == QNAN_ALL) && !run_out);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_out |-> out_valid && !run_out);
  p_seed_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && run_out) |-> (seed_out == 32'd0) && !op_out[31]);
  p_adj_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (adj_out == 8'd0) || (adj_out == TAG_SCL && run_out));
  p_scaled_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && adj_out == TAG_SCL) |-> (op_out[30:23] >= SUB_BASE) && (op_out[30:23] <= SMALL_E + SCALE_E));
  p_unscaled_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && run_out && adj_out == 8'd0) |-> (op_out[30:23] > SMALL_E) && (op_out[30:23] != 8'hFF));

endmodule

// File: tb/sim_rsqrt_prescale.sv
module sim_rsqrt_prescale;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic out_valid, run_out, invalid_out;
  logic [31:0] op_out, seed_out;
  logic [7:0] adj_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rsqrt_prescale u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .op_out(op_out), .seed_out(seed_out),
    .adj_out(adj_out), .run_out(run_out), .invalid_out(invalid_out)
  );

  localparam logic [31:0] NAN_D = 32'hFFFF_FFFF;

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_one(string req, logic [31:0] din, logic [31:0] e_op,
                         logic [31:0] e_seed, logic [7:0] e_adj, logic e_run, logic e_inv);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = din;
    @(posedge clk);
    #1;
    cmp(req, "out_valid", {31'd0, out_valid}, 32'd1);
    cmp(req, "op_out", op_out, e_op);
    cmp(req, "seed_out", seed_out, e_seed);
    cmp(req, "adj_out", {24'd0, adj_out}, {24'd0, e_adj});
    cmp(req, "run_out", {31'd0, run_out}, {31'd0, e_run});
    cmp(req, "invalid_out", {31'd0, invalid_out}, {31'd0, e_inv});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    cmp("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
    cmp("R1", "reset op_out", op_out, 32'd0);
    cmp("R9", "reset invalid_out", {31'd0, invalid_out}, 32'd0);
  endtask

  task automatic t_nan;
    run_one("R2", 32'h7FC0_0000, NAN_D, NAN_D, 8'h00, 1'b0, 1'b0);
    run_one("R2", 32'h7F80_0001, NAN_D, NAN_D, 8'h00, 1'b0, 1'b1);
    run_one("R2", 32'hFFC0_0001, NAN_D, NAN_D, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_negative;
    run_one("R3", 32'hBF80_0000, NAN_D, NAN_D, 8'h00, 1'b0, 1'b1);
    run_one("R3", 32'hFF80_0000, NAN_D, NAN_D, 8'h00, 1'b0, 1'b1);
    run_one("R3", 32'h8000_0001, NAN_D, NAN_D, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_zero;
    run_one("R4", 32'h0000_0000, 32'h0000_0000, 32'h3F80_0000, 8'h00, 1'b0, 1'b0);
    run_one("R4", 32'h8000_0000, 32'h8000_0000, 32'h3F80_0000, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_inf;
    run_one("R5", 32'h7F80_0000, 32'h7F80_0000, 32'h7F80_0000, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_large;
    run_one("R6", 32'h0C92_3456, 32'h0C92_3456, 32'd0, 8'h00, 1'b1, 1'b0);
    run_one("R6", 32'h3F80_0000, 32'h3F80_0000, 32'd0, 8'h00, 1'b1, 1'b0);
    run_one("R6", 32'h7F7F_FFFF, 32'h7F7F_FFFF, 32'd0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_small;
    run_one("R7", 32'h0C12_3456, 32'h2C12_3456, 32'd0, 8'hE0, 1'b1, 1'b0);
    run_one("R7", 32'h0080_0001, 32'h2080_0001, 32'd0, 8'hE0, 1'b1, 1'b0);
  endtask

  task automatic t_subnormal;
    run_one("R8", 32'h0000_0001, 32'h1500_0000, 32'd0, 8'hE0, 1'b1, 1'b0);
    run_one("R8", 32'h0000_0003, 32'h15C0_0000, 32'd0, 8'hE0, 1'b1, 1'b0);
    run_one("R8", 32'h0040_0000, 32'h2000_0000, 32'd0, 8'hE0, 1'b1, 1'b0);
  endtask

  task automatic t_hold;
    run_one("R9", 32'h7F80_0001, NAN_D, NAN_D, 8'h00, 1'b0, 1'b1);
    run_one("R1", 32'h0C12_3456, 32'h2C12_3456, 32'd0, 8'hE0, 1'b1, 1'b0);
    @(negedge clk);
    in_data = 32'hBF80_0000;
    @(posedge clk);
    #1;
    cmp("R1", "idle out_valid", {31'd0, out_valid}, 32'd0);
    cmp("R1", "idle op_out held", op_out, 32'h2C12_3456);
    cmp("R1", "idle adj_out held", {24'd0, adj_out}, 32'h0000_00E0);
    cmp("R9", "idle invalid_out", {31'd0, invalid_out}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_nan();
    t_negative();
    t_zero();
    t_inf();
    t_large();
    t_small();
    t_subnormal();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule